// File: doc/BRIEF.md
# Hardwired Single-Bus Control Sequencer

This block is the control unit of a small 32-bit load/store processor in which almost every register shares one data bus. For each clock step it produces a control word. Each bit of that word is a gate, which puts a value on the bus, or a strobe, which loads a register from the bus or from the ALU. The datapath registers, the ALU and memory sit outside the block. The sequencer sees only the opcode field of the instruction register, a memory completion flag, the branch condition flag, a shift-count-is-zero flag and a reset-request flag.

A time-step counter runs from T0 to T7. The first three steps fetch the instruction and are the same for every opcode. The remaining steps depend on the decoded instruction class. The counter holds while a memory-hold bit is active and completion has not arrived. The shift instruction repeats one step while its count is nonzero. A done bit sends the counter back to T0. A pending reset request overrides every step, whatever the opcode.

Top module: `seq_ctl_unit`

## Requirements
- R1: The control word uses these bit positions: 0 pc_drv, 1 pc_ld, 2 mar_ld, 3 mdr_drv, 4 mdr_ld, 5 ir_ld, 6 opa_ld, 7 res_drv, 8 res_ld, 9 alu_add, 10 alu_inc4, 11 alu_pass, 12 alu_shr, 13 sel_ra, 14 sel_rb, 15 sel_rc, 16 reg_drv, 17 base_drv, 18 reg_ld, 19 imm2_drv, 20 imm1_drv, 21 cnt_ld, 22 cnt_dec, 23 flag_ld, 24 mem_rd, 25 mem_wr, 26 mem_hold, 27 seq_done, 28 pc_clr, 29 rst_clr. After synchronous reset the block is in T0 and drives the T0 fetch word.
- R2: The fetch steps are the same for every opcode. T0 sets pc_drv, mar_ld, alu_inc4, res_ld and mem_rd. T1 sets res_drv, pc_ld and mem_hold. T2 sets mdr_drv and ir_ld. The block then enters T3.
- R3: While mem_hold is set and mem_done is low, the step does not change. The step advances on the first clock with mem_done high.
- R4: add (opcode 12) sets sel_rb, reg_drv and opa_ld in T3. T4 sets sel_rc, reg_drv, alu_add and res_ld. T5 sets res_drv, sel_ra, reg_ld and seq_done.
- R5: addi (opcode 13) matches add, except that T4 sets imm2_drv, alu_add and res_ld.
- R6: st (opcode 3) sets sel_rb, base_drv and opa_ld in T3. T4 sets imm2_drv, alu_add and res_ld. T5 sets res_drv and mar_ld. T6 sets sel_ra, reg_drv, mdr_ld and mem_wr. T7 sets mem_hold and seq_done.
- R7: ld (opcode 1) uses the same T3–T5 as st. T6 sets mem_rd and mem_hold. T7 sets mdr_drv, sel_ra, reg_ld and seq_done.
- R8: shr (opcode 26) sets imm1_drv and cnt_ld in T3. T4 sets sel_rc, reg_drv and cnt_ld only when count_zero is high, and nothing otherwise. T5 sets sel_rb, reg_drv, alu_pass and res_ld. T6 repeats while count_zero is low and sets res_drv, alu_shr, res_ld and cnt_dec. With count_zero high, T6 sets nothing and moves to T7. T7 sets res_drv, sel_ra, reg_ld and seq_done.
- R9: br (opcode 8) sets sel_rc, reg_drv and flag_ld in T3. T4 sets sel_rb, reg_drv and seq_done, and also sets pc_ld only when cond_flag is 1.
- R10: In the clock after a step that sets seq_done, the block is in T0. If that step also sets mem_hold, the return waits for mem_done.
- R11: While reset_req is high, the word is exactly pc_clr and rst_clr in any step, including a stalled one. The next step is T0.
- R12: An opcode that is not one of the six listed sets only seq_done in T3, so the block goes straight to the next fetch.
- R13: In every step, at most one bus driver is set (pc_drv, mdr_drv, res_drv, reg_drv, base_drv, imm2_drv, imm1_drv). At most one register select is set (sel_ra, sel_rb, sel_rc).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to T0 |
| opcode | input | OP_W (5) | Opcode field of the instruction register |
| mem_done | input | 1 | Memory has completed the pending access |
| cond_flag | input | 1 | Branch condition flag from the datapath |
| count_zero | input | 1 | Shift counter equals zero |
| reset_req | input | 1 | Pending soft reset request flag |
| ctl_word | output | CTL_W (30) | Gate and strobe lines for the current step, bit layout in R1 |

## Verification
The bench builds the block with its default parameters: a 5-bit opcode and a 3-bit step counter. These values reach every opcode value the decoder distinguishes, plus an undecoded one, and all eight steps up to T7. With them the bench can run the store and load tails, a shift that loops several times in T6, and a reset request in the middle of execute and during a stalled fetch.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;

    localparam int CTL_W = 30;

    // control word bit positions
    localparam int B_PC_DRV   = 0;
    localparam int B_PC_LD    = 1;
    localparam int B_MAR_LD   = 2;
    localparam int B_MDR_DRV  = 3;
    localparam int B_MDR_LD   = 4;
    localparam int B_IR_LD    = 5;
    localparam int B_OPA_LD   = 6;
    localparam int B_RES_DRV  = 7;
    localparam int B_RES_LD   = 8;
    localparam int B_ALU_ADD  = 9;
    localparam int B_ALU_INC4 = 10;
    localparam int B_ALU_PASS = 11;
    localparam int B_ALU_SHR  = 12;
    localparam int B_SEL_RA   = 13;
    localparam int B_SEL_RB   = 14;
    localparam int B_SEL_RC   = 15;
    localparam int B_REG_DRV  = 16;
    localparam int B_BASE_DRV = 17;
    localparam int B_REG_LD   = 18;
    localparam int B_IMM2_DRV = 19;
    localparam int B_IMM1_DRV = 20;
    localparam int B_CNT_LD   = 21;
    localparam int B_CNT_DEC  = 22;
    localparam int B_FLAG_LD  = 23;
    localparam int B_MEM_RD   = 24;
    localparam int B_MEM_WR   = 25;
    localparam int B_MEM_HOLD = 26;
    localparam int B_SEQ_DONE = 27;
    localparam int B_PC_CLR   = 28;
    localparam int B_RST_CLR  = 29;

    // opcode values
    localparam int OPC_LD   = 1;
    localparam int OPC_ST   = 3;
    localparam int OPC_BR   = 8;
    localparam int OPC_ADD  = 12;
    localparam int OPC_ADDI = 13;
    localparam int OPC_SHR  = 26;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ADD,
        CL_ADDI,
        CL_LD,
        CL_ST,
        CL_SHR,
        CL_BR
    } op_class_e;

    // how the step counter moves after this cycle
    typedef struct packed {
        logic to_zero;
        logic hold;
        logic again;
    } step_nav_t;

    function automatic logic [CTL_W-1:0] line(input int idx);
        return CTL_W'(1) << idx;
    endfunction

endpackage

// File: rtl/seq_op_decoder.sv
module seq_op_decoder
    import seq_ctl_pkg::*;
#(
    parameter int OP_W = 5
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_e       cls
);
    always_comb begin
        if (opcode == OP_W'(OPC_ADD))       cls = CL_ADD;
        else if (opcode == OP_W'(OPC_ADDI)) cls = CL_ADDI;
        else if (opcode == OP_W'(OPC_LD))   cls = CL_LD;
        else if (opcode == OP_W'(OPC_ST))   cls = CL_ST;
        else if (opcode == OP_W'(OPC_SHR))  cls = CL_SHR;
        else if (opcode == OP_W'(OPC_BR))   cls = CL_BR;
        else                                cls = CL_NONE;
    end
endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter
    import seq_ctl_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  step_nav_t         nav,
    output logic [STEP_W-1:0] step
);
    always_ff @(posedge clk) begin
        if (rst)                      step <= '0;
        else if (nav.to_zero)         step <= '0;
        else if (nav.hold || nav.again) step <= step;
        else                          step <= step + STEP_W'(1);
    end
endmodule

// File: rtl/seq_ctl_logic.sv
module seq_ctl_logic
    import seq_ctl_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step,
    input  op_class_e         cls,
    input  logic              mem_done,
    input  logic              cond_flag,
    input  logic              count_zero,
    input  logic              reset_req,
    output logic [CTL_W-1:0]  word,
    output step_nav_t         nav
);
    localparam logic [CTL_W-1:0] FETCH0 = line(B_PC_DRV) | line(B_MAR_LD) |
        line(B_ALU_INC4) | line(B_RES_LD) | line(B_MEM_RD);
    localparam logic [CTL_W-1:0] FETCH1 = line(B_RES_DRV) | line(B_PC_LD) |
        line(B_MEM_HOLD);
    localparam logic [CTL_W-1:0] FETCH2 = line(B_MDR_DRV) | line(B_IR_LD);
    localparam logic [CTL_W-1:0] WB_RA  = line(B_RES_DRV) | line(B_SEL_RA) |
        line(B_REG_LD) | line(B_SEQ_DONE);
    localparam logic [CTL_W-1:0] IMM_ADD = line(B_IMM2_DRV) | line(B_ALU_ADD) |
        line(B_RES_LD);

    int s;
    logic [CTL_W-1:0] exec_w;

    always_comb begin
        s = int'(step);
        exec_w = '0;
        unique case (cls)
            CL_ADD, CL_ADDI: begin
                if (s == 3) exec_w = line(B_SEL_RB) | line(B_REG_DRV) | line(B_OPA_LD);
                else if (s == 4) begin
                    if (cls == CL_ADD)
                        exec_w = line(B_SEL_RC) | line(B_REG_DRV) | line(B_ALU_ADD) | line(B_RES_LD);
                    else
                        exec_w = IMM_ADD;
                end
                else if (s == 5) exec_w = WB_RA;
            end
            CL_LD, CL_ST: begin
                if (s == 3) exec_w = line(B_SEL_RB) | line(B_BASE_DRV) | line(B_OPA_LD);
                else if (s == 4) exec_w = IMM_ADD;
                else if (s == 5) exec_w = line(B_RES_DRV) | line(B_MAR_LD);
                else if (s == 6) begin
                    if (cls == CL_ST)
                        exec_w = line(B_SEL_RA) | line(B_REG_DRV) | line(B_MDR_LD) | line(B_MEM_WR);
                    else
                        exec_w = line(B_MEM_RD) | line(B_MEM_HOLD);
                end
                else if (s == 7) begin
                    if (cls == CL_ST)
                        exec_w = line(B_MEM_HOLD) | line(B_SEQ_DONE);
                    else
                        exec_w = line(B_MDR_DRV) | line(B_SEL_RA) | line(B_REG_LD) | line(B_SEQ_DONE);
                end
            end
            CL_SHR: begin
                if (s == 3) exec_w = line(B_IMM1_DRV) | line(B_CNT_LD);
                else if (s == 4) begin
                    if (count_zero)
                        exec_w = line(B_SEL_RC) | line(B_REG_DRV) | line(B_CNT_LD);
                end
                else if (s == 5)
                    exec_w = line(B_SEL_RB) | line(B_REG_DRV) | line(B_ALU_PASS) | line(B_RES_LD);
                else if (s == 6) begin
                    if (!count_zero)
                        exec_w = line(B_RES_DRV) | line(B_ALU_SHR) | line(B_RES_LD) | line(B_CNT_DEC);
                end
                else if (s == 7) exec_w = WB_RA;
            end
            CL_BR: begin
                if (s == 3) exec_w = line(B_SEL_RC) | line(B_REG_DRV) | line(B_FLAG_LD);
                else if (s == 4)
                    exec_w = line(B_SEL_RB) | line(B_REG_DRV) | line(B_SEQ_DONE) |
                             (cond_flag ? line(B_PC_LD) : '0);
            end
            default: begin
                if (s == 3) exec_w = line(B_SEQ_DONE);
            end
        endcase
    end

    always_comb begin
        if (reset_req)   word = line(B_PC_CLR) | line(B_RST_CLR);
        else if (s == 0) word = FETCH0;
        else if (s == 1) word = FETCH1;
        else if (s == 2) word = FETCH2;
        else             word = exec_w;
    end

    always_comb begin
        nav.hold    = !reset_req && word[B_MEM_HOLD] && !mem_done;
        nav.to_zero = reset_req || (word[B_SEQ_DONE] && !nav.hold);
        nav.again   = !reset_req && cls == CL_SHR && s == 6 && !count_zero;
    end
endmodule

// File: rtl/seq_ctl_unit.sv
module seq_ctl_unit
    import seq_ctl_pkg::*;
#(
    parameter int OP_W   = 5,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    input  logic              mem_done,
    input  logic              cond_flag,
    input  logic              count_zero,
    input  logic              reset_req,
    output logic [CTL_W-1:0]  ctl_word
);
    op_class_e         cls;
    step_nav_t         nav;
    logic [STEP_W-1:0] step;

    seq_op_decoder #(.OP_W(OP_W)) u_dec (
        .opcode (opcode),
        .cls    (cls)
    );

    seq_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .nav  (nav),
        .step (step)
    );

    seq_ctl_logic #(.STEP_W(STEP_W)) u_logic (
        .step       (step),
        .cls        (cls),
        .mem_done   (mem_done),
        .cond_flag  (cond_flag),
        .count_zero (count_zero),
        .reset_req  (reset_req),
        .word       (ctl_word),
        .nav        (nav)
    );
endmodule

// File: rtl/seq_ctl_unit_chk.sv
module seq_ctl_unit_chk
    import seq_ctl_pkg::*;
#(
    parameter int OP_W   = 5,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   opcode,
    input logic              mem_done,
    input logic              count_zero,
    input logic              reset_req,
    input logic [CTL_W-1:0]  ctl_word,
    input logic [STEP_W-1:0] step
);
    logic [6:0] drivers;
    assign drivers = {ctl_word[B_PC_DRV], ctl_word[B_MDR_DRV], ctl_word[B_RES_DRV],
                      ctl_word[B_REG_DRV], ctl_word[B_BASE_DRV], ctl_word[B_IMM2_DRV],
                      ctl_word[B_IMM1_DRV]};

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[B_MEM_HOLD] && !mem_done && !reset_req) |=> step == $past(step));

    a_r10_done_to_t0: assert property (@(posedge clk) disable iff (rst)
        (ctl_word[B_SEQ_DONE] && !ctl_word[B_MEM_HOLD]) |=> step == '0);

    a_r11_reset_to_t0: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> step == '0);

    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> ($countones(ctl_word) == 2 && ctl_word[B_PC_CLR] && ctl_word[B_RST_CLR]));

    a_r2_fetch_enters_t3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_W'(2) && !reset_req) |=> step == STEP_W'(3));

    a_r8_shift_repeats: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_W'(6) && opcode == OP_W'(OPC_SHR) && !count_zero && !reset_req)
        |=> step == STEP_W'(6));

    a_r13_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drivers));

    a_r13_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_word[B_SEL_RA], ctl_word[B_SEL_RB], ctl_word[B_SEL_RC]}));
endmodule

bind seq_ctl_unit seq_ctl_unit_chk #(.OP_W(OP_W), .STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .mem_done   (mem_done),
    .count_zero (count_zero),
    .reset_req  (reset_req),
    .ctl_word   (ctl_word),
    .step       (step)
);

// File: tb/seq_ctl_unit_bench.sv
module seq_ctl_unit_bench;
    localparam int W = 30;
    localparam logic [W-1:0] PC_DRV = 30'h1 << 0,  PC_LD = 30'h1 << 1,  MAR_LD = 30'h1 << 2;
    localparam logic [W-1:0] MDR_DRV = 30'h1 << 3, MDR_LD = 30'h1 << 4, IR_LD = 30'h1 << 5;
    localparam logic [W-1:0] OPA_LD = 30'h1 << 6,  RES_DRV = 30'h1 << 7, RES_LD = 30'h1 << 8;
    localparam logic [W-1:0] ADD = 30'h1 << 9,     INC4 = 30'h1 << 10,  PASS = 30'h1 << 11;
    localparam logic [W-1:0] SHR = 30'h1 << 12,    SRA = 30'h1 << 13,   SRB = 30'h1 << 14;
    localparam logic [W-1:0] SRC = 30'h1 << 15,    REG_DRV = 30'h1 << 16, BASE_DRV = 30'h1 << 17;
    localparam logic [W-1:0] REG_LD = 30'h1 << 18, IMM2 = 30'h1 << 19,  IMM1 = 30'h1 << 20;
    localparam logic [W-1:0] CNT_LD = 30'h1 << 21, CNT_DEC = 30'h1 << 22, FLAG_LD = 30'h1 << 23;
    localparam logic [W-1:0] RD = 30'h1 << 24,     WR = 30'h1 << 25,    HOLD = 30'h1 << 26;
    localparam logic [W-1:0] DONE = 30'h1 << 27,   PC_CLR = 30'h1 << 28, RST_CLR = 30'h1 << 29;

    localparam logic [W-1:0] F0 = PC_DRV | MAR_LD | INC4 | RES_LD | RD;
    localparam logic [W-1:0] F1 = RES_DRV | PC_LD | HOLD;
    localparam logic [W-1:0] F2 = MDR_DRV | IR_LD;
    localparam logic [W-1:0] WB = RES_DRV | SRA | REG_LD | DONE;
    localparam logic [W-1:0] BUSDRV = PC_DRV | MDR_DRV | RES_DRV | REG_DRV | BASE_DRV | IMM2 | IMM1;
    localparam logic [W-1:0] SELS = SRA | SRB | SRC;

    logic clk = 0, rst = 1;
    logic [4:0] opcode = '0;
    logic mem_done = 0, cond_flag = 0, count_zero = 0, reset_req = 0;
    logic [W-1:0] ctl;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    seq_ctl_unit u_seq_ctl_unit (
        .clk(clk), .rst(rst), .opcode(opcode), .mem_done(mem_done),
        .cond_flag(cond_flag), .count_zero(count_zero), .reset_req(reset_req),
        .ctl_word(ctl)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic [W-1:0] exp, input string tag);
        #1;
        checks++;
        if (ctl !== exp) begin
            errors++;
            $display("FAIL %s: ctl=%h expected %h", tag, ctl, exp);
        end
        checks++;
        if ($countones(ctl & BUSDRV) > 1 || $countones(ctl & SELS) > 1) begin
            errors++;
            $display("FAIL R13 (%s): ctl=%h expected at most one driver/select", tag, ctl);
        end
    endtask

    task automatic fetch(input logic [4:0] op);
        opcode = op;
        mem_done = 0;
        chk(F0, "R2 T0");
        tick();
        chk(F1, "R2 T1");
        tick();
        chk(F1, "R3 T1 stalled");
        tick();
        chk(F1, "R3 T1 still stalled");
        mem_done = 1;
        chk(F1, "R3 T1 done");
        tick();
        mem_done = 0;
        chk(F2, "R2 T2");
        tick();
    endtask

    task automatic t_add(input logic imm);
        fetch(imm ? 5'd13 : 5'd12);
        chk(SRB | REG_DRV | OPA_LD, imm ? "R5 T3" : "R4 T3");
        tick();
        if (imm) chk(IMM2 | ADD | RES_LD, "R5 T4");
        else     chk(SRC | REG_DRV | ADD | RES_LD, "R4 T4");
        tick();
        chk(WB, imm ? "R5 T5" : "R4 T5");
        tick();
        chk(F0, "R10 back to T0");
    endtask

    task automatic t_mem(input logic store);
        fetch(store ? 5'd3 : 5'd1);
        chk(SRB | BASE_DRV | OPA_LD, store ? "R6 T3" : "R7 T3");
        tick();
        chk(IMM2 | ADD | RES_LD, store ? "R6 T4" : "R7 T4");
        tick();
        chk(RES_DRV | MAR_LD, store ? "R6 T5" : "R7 T5");
        tick();
        if (store) chk(SRA | REG_DRV | MDR_LD | WR, "R6 T6");
        else       chk(RD | HOLD, "R7 T6");
        if (!store) begin
            tick();
            chk(RD | HOLD, "R3 ld T6 stalled");
            mem_done = 1;
            tick();
            mem_done = 0;
            chk(MDR_DRV | SRA | REG_LD | DONE, "R7 T7");
            tick();
            chk(F0, "R10 ld back to T0");
        end else begin
            tick();
            chk(HOLD | DONE, "R6 T7");
            tick();
            chk(HOLD | DONE, "R10 st T7 waits for done");
            mem_done = 1;
            tick();
            mem_done = 0;
            chk(F0, "R10 st back to T0");
        end
    endtask

    task automatic t_shr(input logic cnt_from_reg);
        fetch(5'd26);
        chk(IMM1 | CNT_LD, "R8 T3");
        tick();
        count_zero = cnt_from_reg;
        chk(cnt_from_reg ? (SRC | REG_DRV | CNT_LD) : '0, "R8 T4");
        tick();
        count_zero = 0;
        chk(SRB | REG_DRV | PASS | RES_LD, "R8 T5");
        tick();
        for (int i = 0; i < 3; i++) begin
            chk(RES_DRV | SHR | RES_LD | CNT_DEC, "R8 T6 loop");
            tick();
        end
        count_zero = 1;
        chk('0, "R8 T6 count zero");
        tick();
        count_zero = 0;
        chk(WB, "R8 T7");
        tick();
        chk(F0, "R10 shr back to T0");
    endtask

    task automatic t_br(input logic c);
        fetch(5'd8);
        chk(SRC | REG_DRV | FLAG_LD, "R9 T3");
        tick();
        cond_flag = c;
        chk(SRB | REG_DRV | DONE | (c ? PC_LD : '0), c ? "R9 T4 taken" : "R9 T4 not taken");
        tick();
        cond_flag = 0;
        chk(F0, "R10 br back to T0");
    endtask

    task automatic t_undecoded();
        fetch(5'd31);
        chk(DONE, "R12 T3");
        tick();
        chk(F0, "R12 back to T0");
    endtask

    task automatic t_reset_req();
        fetch(5'd12);
        tick();
        reset_req = 1;
        chk(PC_CLR | RST_CLR, "R11 in T4");
        tick();
        reset_req = 0;
        chk(F0, "R11 returns to T0");
        tick();
        chk(F1, "R11 next fetch T1");
        reset_req = 1;
        chk(PC_CLR | RST_CLR, "R11 in stalled T1");
        tick();
        reset_req = 0;
        chk(F0, "R11 stall abandoned");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(F0, "R1 reset state");
        rst = 0;
        tick();
        chk(F1, "R1 leaves T0 after reset");
        rst = 1;
        tick();
        rst = 0;
        t_add(0);
        t_add(1);
        t_mem(1);
        t_mem(0);
        t_shr(0);
        t_shr(1);
        t_br(1);
        t_br(0);
        t_undecoded();
        t_reset_req();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule